// File: doc/BRIEF.md
# Dual-Clock Word FIFO with Reset-Chosen Write Mode

This block is a first-in first-out buffer for 9-bit words whose write side and read side run on unrelated clocks. Words enter on the write clock and leave, in arrival order, through a registered output on the read clock. Two active-low flags tell each side when it must stop: `full_n` in the write domain and `empty_n` in the read domain. Writes into a full buffer and reads from an empty one are refused. A refused read leaves the output register untouched.

How writes are enabled is decided once, during reset. The level on `wr_en2_ld` while reset is applied is captured. If it is high, a write needs `wr_en1_n` low and `wr_en2_ld` high at the same time, so several buffers can share one write bus and be stacked in depth. If it is low, `wr_en1_n` alone controls writes and `wr_en2_ld` is ignored until the next reset. A read needs both `rd_en1_n` and `rd_en2_n` low. An active-low output enable does not switch any pin to high impedance. Instead it drives a separate `rd_drive` qualifier.

The pointers are Gray-coded and one bit wider than the address. Each pointer crosses into the other domain through a flop chain. This makes both flags conservative: a flag can report full or empty for a few cycles longer than the true state, but it never reports less.

Top module: `dcf_fifo9`

## Requirements
- R1: After reset, `empty_n` is 0, `full_n` is 1 and `rd_data` is all zeros. Any words held before the reset are discarded.
- R2: The level of `wr_en2_ld` while `rst` is high selects the write mode. 1 selects dual-enable mode and 0 selects single-enable mode. The mode does not change until the next reset.
- R3: In dual-enable mode, a word is stored on a rising `wr_clk` edge only when `wr_en1_n`=0, `wr_en2_ld`=1 and `full_n`=1.
- R4: In single-enable mode, a word is stored on a rising `wr_clk` edge when `wr_en1_n`=0 and `full_n`=1, whatever the level of `wr_en2_ld`.
- R5: On a rising `rd_clk` edge with `rd_en1_n`=0, `rd_en2_n`=0 and `empty_n`=1, the oldest unread word is loaded into `rd_data`. Words appear in the order they were stored.
- R6: A write attempt while `full_n`=0 is discarded. It never overwrites an unread word and never appears at the output.
- R7: On any `rd_clk` edge that does not perform a read, `rd_data` keeps its previous value. This covers both an enable held high and an attempt made while `empty_n`=0.
- R8: With no reads, `full_n` falls after exactly DEPTH stored words. `full_n`=1 only while fewer than DEPTH words are unread, and `empty_n`=1 only while at least one word is unread.
- R9: `rd_drive` is 1 exactly when `oe_n` is 0. `oe_n` has no effect on the words delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst | input | 1 | Active-high reset, synchronised into each domain |
| wr_en1_n | input | 1 | Primary write enable, active low |
| wr_en2_ld | input | 1 | Second write enable (active high); sampled during reset to select the mode |
| wr_data | input | DATA_W (9) | Word to store |
| rd_en1_n | input | 1 | First read enable, active low |
| rd_en2_n | input | 1 | Second read enable, active low |
| oe_n | input | 1 | Output enable, active low |
| rd_data | output | DATA_W (9) | Registered output word |
| rd_drive | output | 1 | High when the output is to be driven |
| empty_n | output | 1 | Empty flag, active low, read domain |
| full_n | output | 1 | Full flag, active low, write domain |

## Verification
The bench builds the block with DEPTH=16 and two synchroniser stages. With this small depth, a burst from a write side that is faster than the read side pushes the buffer against `full_n` many times in each random phase, and the exact fill count can be checked directly. The write clock runs at 20 ns and the read clock at 28 ns. Because the two periods do not divide evenly, flag updates cross the domains at phases that keep shifting. Random phases run in both write modes, with the second enable toggling, so the run shows that mode selection and the refusal rules at full and at empty hold up across many orderings.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int PTR_MAX = 16;
  typedef logic [PTR_MAX-1:0] ptr_t;

  function automatic ptr_t bin2gray(ptr_t b);
    return b ^ (b >> 1);
  endfunction
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) stg[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk) stg[i] <= stg[i-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 6
) (
  input  logic              wr_clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] dout
);
  localparam int WORDS = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge wr_clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // output register with synchronous clear; holds its word when no read happens
  always_ff @(posedge rd_clk) begin
    if (rd_rst)     dout <= '0;
    else if (rd_en) dout <= mem[rd_addr];
  end

  AST_HOLD_LAST: assert property (@(posedge rd_clk) disable iff (rd_rst)
    !rd_en |=> $stable(dout)); // R7
endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl
  import dcf_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en1_n,
  input  logic            en2_ld,
  input  logic [ADDR_W:0] rd_gray_sync,
  output logic            wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W:0] wr_gray,
  output logic            full_n
);
  localparam int PTR_W = ADDR_W + 1;

  logic             mode_dual;
  logic             full;
  logic             wr_req;
  logic [PTR_W-1:0] bin, bin_nxt, gray_nxt, full_cmp;

  assign wr_req   = mode_dual ? (!en1_n && en2_ld) : !en1_n;
  assign wr_en    = wr_req && !full;
  assign bin_nxt  = bin + PTR_W'(wr_en);
  assign gray_nxt = PTR_W'(bin2gray(ptr_t'(bin_nxt)));
  // full when write pointer has lapped the read pointer: two top Gray bits inverted
  assign full_cmp = {~rd_gray_sync[PTR_W-1:PTR_W-2], rd_gray_sync[PTR_W-3:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_dual <= en2_ld;
      bin       <= '0;
      wr_gray   <= '0;
      full      <= 1'b0;
    end else begin
      bin     <= bin_nxt;
      wr_gray <= gray_nxt;
      full    <= (gray_nxt == full_cmp);
    end
  end

  assign wr_addr = bin[ADDR_W-1:0];
  assign full_n  = !full;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (full && wr_req) |=> $stable(bin)); // R6
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(mode_dual)); // R2
  AST_WR_GRAY_STEP: assert property (@(posedge clk) disable iff (rst)
    $countones(wr_gray ^ $past(wr_gray)) <= 1); // R5
endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl
  import dcf_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en1_n,
  input  logic              en2_n,
  input  logic [ADDR_W:0]   wr_gray_sync,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W:0]   rd_gray,
  output logic              empty_n
);
  localparam int PTR_W = ADDR_W + 1;

  logic             empty;
  logic             rd_req;
  logic [PTR_W-1:0] bin, bin_nxt, gray_nxt;

  assign rd_req   = !en1_n && !en2_n;
  assign rd_en    = rd_req && !empty;
  assign bin_nxt  = bin + PTR_W'(rd_en);
  assign gray_nxt = PTR_W'(bin2gray(ptr_t'(bin_nxt)));

  always_ff @(posedge clk) begin
    if (rst) begin
      bin     <= '0;
      rd_gray <= '0;
      empty   <= 1'b1;
    end else begin
      bin     <= bin_nxt;
      rd_gray <= gray_nxt;
      empty   <= (gray_nxt == wr_gray_sync);
    end
  end

  assign rd_addr = bin[ADDR_W-1:0];
  assign empty_n = !empty;

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (empty && rd_req) |=> $stable(bin)); // R7
  AST_EMPTY_ON_RESET: assert property (@(posedge clk)
    $fell(rst) |-> empty); // R1
  AST_RD_GRAY_STEP: assert property (@(posedge clk) disable iff (rst)
    $countones(rd_gray ^ $past(rd_gray)) <= 1); // R5
endmodule

// File: rtl/dcf_fifo9.sv
module dcf_fifo9 #(
  parameter int DATA_W      = 9,
  parameter int DEPTH       = 64,   // power of two, at least 4
  parameter int SYNC_STAGES = 2
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst,
  input  logic              wr_en1_n,
  input  logic              wr_en2_ld,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en1_n,
  input  logic              rd_en2_n,
  input  logic              oe_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_drive,
  output logic              empty_n,
  output logic              full_n
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int PTR_W  = ADDR_W + 1;

  logic              wr_rst, rd_rst;
  logic              wr_en, rd_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [PTR_W-1:0]  wr_gray, rd_gray, wr_gray_rs, rd_gray_ws;

  dcf_sync #(.W(1), .STAGES(SYNC_STAGES)) u_wr_rst (
    .clk(wr_clk), .d(rst), .q(wr_rst));
  dcf_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rd_rst (
    .clk(rd_clk), .d(rst), .q(rd_rst));

  dcf_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rd_clk), .d(wr_gray), .q(wr_gray_rs));
  dcf_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wr_clk), .d(rd_gray), .q(rd_gray_ws));

  dcf_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
    .clk(wr_clk), .rst(wr_rst), .en1_n(wr_en1_n), .en2_ld(wr_en2_ld),
    .rd_gray_sync(rd_gray_ws), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_gray(wr_gray), .full_n(full_n));

  dcf_rd_ctrl #(.ADDR_W(ADDR_W)) u_rd (
    .clk(rd_clk), .rst(rd_rst), .en1_n(rd_en1_n), .en2_n(rd_en2_n),
    .wr_gray_sync(wr_gray_rs), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_gray(rd_gray), .empty_n(empty_n));

  dcf_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .wr_clk(wr_clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en), .rd_addr(rd_addr),
    .dout(rd_data));

  assign rd_drive = !oe_n;
endmodule

// File: tb/dcf_fifo9_tb.sv
module dcf_fifo9_tb;
  localparam int DW = 9;
  localparam int DEPTH = 16;

  logic wr_clk = 0, rd_clk = 0;
  always #10 wr_clk = ~wr_clk;
  always #14 rd_clk = ~rd_clk;

  logic rst, wr_en1_n, wr_en2_ld, rd_en1_n, rd_en2_n, oe_n;
  logic [DW-1:0] wr_data, rd_data;
  logic rd_drive, empty_n, full_n;

  dcf_fifo9 #(.DATA_W(DW), .DEPTH(DEPTH), .SYNC_STAGES(2)) u_dut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .wr_en1_n(wr_en1_n),
    .wr_en2_ld(wr_en2_ld), .wr_data(wr_data), .rd_en1_n(rd_en1_n),
    .rd_en2_n(rd_en2_n), .oe_n(oe_n), .rd_data(rd_data),
    .rd_drive(rd_drive), .empty_n(empty_n), .full_n(full_n));

  int n_chk = 0, n_bad = 0;
  bit mode_dual;
  bit done = 0;
  logic [DW-1:0] model_q[$];
  logic [DW-1:0] last_rd;

  function automatic bit exp_wr(bit dual, bit w1n, bit w2);
    return dual ? (!w1n && w2) : !w1n;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(bit dual);
    rst = 1; wr_en2_ld = dual; wr_en1_n = 1; rd_en1_n = 1; rd_en2_n = 1;
    oe_n = 0; wr_data = '0;
    repeat (8) @(negedge wr_clk);
    repeat (8) @(negedge rd_clk);
    rst = 0;
    repeat (6) @(negedge wr_clk);
    repeat (6) @(negedge rd_clk);
    mode_dual = dual;
    model_q.delete();
    last_rd = '0;
    check(rd_data == '0, "R1 rd_data", int'(rd_data), 0);
    check(empty_n == 1'b0, "R1 empty_n", int'(empty_n), 0);
    check(full_n == 1'b1, "R1 full_n", int'(full_n), 1);
  endtask

  task automatic wr_run(int n, int pct);
    for (int i = 0; i < n; i++) begin
      bit w1n, w2, acc;
      logic [DW-1:0] d;
      @(negedge wr_clk);
      if (full_n)
        check(model_q.size() < DEPTH, "R8 full_n high with buffer full",
              model_q.size(), DEPTH - 1);
      w1n = !($urandom_range(99) < pct);
      w2  = ($urandom_range(3) != 0);
      d   = DW'($urandom);
      acc = exp_wr(mode_dual, w1n, w2) && full_n;
      wr_en1_n = w1n; wr_en2_ld = w2; wr_data = d;
      if (acc) model_q.push_back(d);
    end
    @(negedge wr_clk);
    wr_en1_n = 1;
  endtask

  task automatic rd_run(int n, int pct);
    bit prev_acc = 0;
    logic [DW-1:0] exp_d = '0;
    string wt;
    for (int i = 0; i <= n; i++) begin
      bit e1, e2, acc, o;
      @(negedge rd_clk);
      wt = mode_dual ? "R3" : "R4";
      if (i > 0) begin
        if (prev_acc) begin
          check(rd_data == exp_d, $sformatf("R5 word order (%s)", wt),
                int'(rd_data), int'(exp_d));
          last_rd = exp_d;
        end else begin
          check(rd_data == last_rd, "R7 output held", int'(rd_data), int'(last_rd));
        end
      end
      if (empty_n)
        check(model_q.size() > 0, "R8 empty_n high with nothing unread",
              model_q.size(), 1);
      if (i < n) begin
        if ($urandom_range(99) < pct) begin e1 = 0; e2 = 0; end
        else begin e1 = 1'($urandom_range(1)); e2 = 1'($urandom_range(1)); end
        o = 1'($urandom_range(1));
      end else begin
        e1 = 1; e2 = 1; o = 0;
      end
      acc = !e1 && !e2 && empty_n && (model_q.size() > 0);
      if (acc) exp_d = model_q.pop_front();
      rd_en1_n = e1; rd_en2_n = e2; oe_n = o;
      #1;
      check(rd_drive == !o, "R9 rd_drive", int'(rd_drive), int'(!o));
      prev_acc = acc;
    end
  endtask

  initial begin
    int accepted;
    void'($urandom(32'd20240611));

    // R2/R3: dual mode refuses a write with the second enable low
    do_reset(1);
    @(negedge wr_clk); wr_en1_n = 0; wr_en2_ld = 0; wr_data = 9'h155;
    @(negedge wr_clk); wr_en1_n = 1; wr_en2_ld = 1;
    repeat (12) @(negedge rd_clk);
    check(empty_n == 1'b0, "R2 R3 dual mode stored word with wr_en2_ld low", int'(empty_n), 0);

    // R2/R4: single mode writes with wr_en1_n alone
    do_reset(0);
    @(negedge wr_clk); wr_en1_n = 0; wr_en2_ld = 0; wr_data = 9'h0a3;
    model_q.push_back(9'h0a3);
    @(negedge wr_clk); wr_en1_n = 1; wr_en2_ld = 1;
    repeat (12) @(negedge rd_clk);
    check(empty_n == 1'b1, "R2 R4 single mode write missing", int'(empty_n), 1);
    rd_run(4, 100);
    check(rd_data == 9'h0a3, "R4 single-mode word", int'(rd_data), 9'h0a3);

    // R8/R6: exact fill, then refused writes must not appear
    do_reset(1);
    accepted = 0;
    for (int i = 0; i < DEPTH + 6; i++) begin
      @(negedge wr_clk);
      if (full_n) begin accepted++; model_q.push_back(DW'(i)); end
      wr_en1_n = 0; wr_en2_ld = 1; wr_data = DW'(i);
    end
    @(negedge wr_clk); wr_en1_n = 1;
    @(negedge wr_clk);
    check(accepted == DEPTH, "R8 words accepted before full", accepted, DEPTH);
    check(full_n == 1'b0, "R8 full_n after fill", int'(full_n), 0);
    rd_run(DEPTH + 8, 100);
    check(rd_data == DW'(DEPTH - 1), "R6 last word is final accepted one",
          int'(rd_data), DEPTH - 1);
    check(empty_n == 1'b0, "R7 empty after drain", int'(empty_n), 0);
    rd_run(6, 100);
    check(rd_data == DW'(DEPTH - 1), "R7 reads on empty keep last word",
          int'(rd_data), DEPTH - 1);

    // R1: reset while holding words discards them
    wr_run(6, 100);
    do_reset(1);

    // random traffic, dual mode, balanced
    fork
      wr_run(1500, 50);
      rd_run(1100, 50);
    join
    rd_run(DEPTH + 20, 100);

    // random traffic, single mode, writer dominant to hit full often
    do_reset(0);
    fork
      wr_run(1500, 85);
      rd_run(1100, 35);
    join
    rd_run(DEPTH + 20, 100);
    check(empty_n == 1'b0, "R8 empty at end", int'(empty_n), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge wr_clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule